// File: doc/BRIEF.md
# Capacitive Proximity Event Detector

This block sits behind a capacitive sensing front end and turns a stream of signed 12-bit difference samples into a single close/far decision. Each sample arrives with a one-cycle strobe. The block compares it against a programmable detection level. A hysteresis band is set above and below that level. A run of qualifying samples must be seen before the decision flips, and the run length is set separately for each direction. Confirmed transitions are recorded as sticky interrupt source bits. Each completed conversion is also recorded, and a mask combines the source bits into one interrupt line.

The detection level comes from an 8-bit code. Codes 0 and 1 give a level equal to the code. Any larger code c gives floor(c*c/2), so the level spans a wide range in coarse steps. The band width is derived from the level by a right shift that a 2-bit code selects. Software sets the codes and reads status and events through a small synchronous register port. A read of the source register returns the pending events and clears them.

The decision is held by a four-state machine:
- ST_FAR: idle far.
- ST_FAR_ARM: far, counting toward close.
- ST_CLOSE: idle close.
- ST_CLOSE_ARM: close, counting toward far.

On a strobe, the machine moves as follows:
- ST_FAR or ST_FAR_ARM moves to ST_FAR_ARM on a qualifying sample while the run is still short of the target.
- ST_FAR or ST_FAR_ARM moves to ST_CLOSE when the run reaches the target. This raises a close event.
- ST_FAR_ARM falls back to ST_FAR on a non-qualifying sample.
- ST_CLOSE and ST_CLOSE_ARM behave the same way toward ST_FAR, with a far event on arrival.
- Without a strobe, nothing moves.

Top module: `prox_event_detect`

## Requirements
- R1: The detection level T equals the threshold code c when c is 0 or 1, and floor(c*c/2) for c of 2 or more. The threshold code is held at register address 3 and resets to 8, so T resets to 32.
- R2: The band B is 0 for hysteresis code 0, and T>>4, T>>3 and T>>2 for codes 1, 2 and 3. A sample qualifies for close when it is strictly greater than T+B. It qualifies for far when it is strictly less than T-B. A sample between those limits qualifies for neither.
- R3: With close run code n (0..3), the state becomes close on the sample that completes 1 consecutive close-qualifying sample when n is 0, or 2^n such samples otherwise.
- R4: With far run code m (0..3), the state becomes far on the sample that completes 1 consecutive far-qualifying sample when m is 0, or 2^m such samples otherwise.
- R5: A strobed sample that does not qualify in the pending direction resets the run, so counting restarts from zero.
- R6: State, run count and events change only on cycles where sample_valid is high. Idle cycles between strobes neither break nor advance a run.
- R7: The source register (address 0) is sticky. Bit 0 sets on every strobe in any state. Bit 2 sets when the state becomes far. Bit 3 sets when the state becomes close. All other bits read 0.
- R8: A read of address 0 returns the source bits and clears them. An event that occurs in the same cycle as the read is kept for the next read and is not in the returned value.
- R9: irq is high exactly when the source register and the mask register (address 2, same bit positions, only bits 0, 2 and 3 kept) share a set bit.
- R10: The tuning register is at address 4, with fields [1:0] close run code, [3:2] far run code and [5:4] hysteresis code, and it resets to 0. The mask resets to 0. Writes to addresses 0 and 1 and to unmapped addresses change nothing. Reads of unmapped addresses return 0. Read data appears on reg_rdata in the cycle after reg_rd.
- R11: prox_close is 1 while the state is close. Address 1 reads it in bit 0, with all other bits 0. After reset the state is far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Strobe: sample_data holds a new conversion |
| sample_data | input | 12 | Signed difference sample |
| reg_wr | input | 1 | Register write enable |
| reg_rd | input | 1 | Register read enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid the cycle after reg_rd |
| prox_close | output | 1 | Current decision, 1 = close |
| irq | output | 1 | Masked OR of the pending source bits |

## Verification
A wrong run count or a wrong state appears on prox_close at the first strobe where the decision should or should not flip. That is one strobe late or early at the run boundary, so the bench samples prox_close right after the exact strobe that should complete each run, and right after the one before it. A wrong level or band appears at the boundary sample values T+B, T+B+1, T-B and T-B-1, which the bench sweeps over many codes. A lost or stuck event bit appears on irq and on the next source read.

// File: rtl/prox_det_pkg.sv
package prox_det_pkg;

    localparam int REG_ADDR_W = 3;
    localparam int REG_DATA_W = 8;
    localparam int DEB_W      = 2;
    localparam int HYST_W     = 2;

    localparam int SRC_CONV_BIT  = 0;
    localparam int SRC_FAR_BIT   = 2;
    localparam int SRC_CLOSE_BIT = 3;
    localparam logic [REG_DATA_W-1:0] SRC_USED =
        REG_DATA_W'((1 << SRC_CONV_BIT) | (1 << SRC_FAR_BIT) | (1 << SRC_CLOSE_BIT));

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_SRC    = 3'd0,
        RA_STATUS = 3'd1,
        RA_MASK   = 3'd2,
        RA_THRESH = 3'd3,
        RA_TUNE   = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_FAR,
        ST_FAR_ARM,
        ST_CLOSE,
        ST_CLOSE_ARM
    } prox_state_e;

    typedef struct packed {
        logic [HYST_W-1:0] hyst;
        logic [DEB_W-1:0]  far_deb;
        logic [DEB_W-1:0]  close_deb;
    } tune_t;

endpackage

// File: rtl/prox_level_cmp.sv
module prox_level_cmp
    import prox_det_pkg::*;
#(
    parameter int SAMPLE_W   = 12,
    parameter int THR_CODE_W = 8,
    localparam int THR_W     = 2 * THR_CODE_W,
    localparam int CMP_W     = THR_W + 2
) (
    input  logic [THR_CODE_W-1:0] thr_code,
    input  logic [HYST_W-1:0]     hyst_code,
    input  logic [SAMPLE_W-1:0]   sample,
    output logic [THR_W-1:0]      level,
    output logic [THR_W-1:0]      band,
    output logic                  close_hit,
    output logic                  far_hit
);
    localparam int NUM_HYST  = 1 << HYST_W;
    localparam int HYST_SPAN = NUM_HYST + 1;

    logic [THR_W-1:0]        square;
    logic [THR_W:0]          upper;
    logic [THR_W-1:0]        lower;
    logic signed [CMP_W-1:0] sample_x;

    always_comb begin
        square = THR_W'(thr_code) * THR_W'(thr_code);
        if (thr_code <= THR_CODE_W'(1))
            level = THR_W'(thr_code);
        else
            level = square >> 1;
    end

    always_comb begin
        band = '0;
        for (int k = 1; k < NUM_HYST; k++) begin
            if (hyst_code == HYST_W'(k))
                band = level >> (HYST_SPAN - k);
        end
    end

    always_comb begin
        upper    = {1'b0, level} + {1'b0, band};
        lower    = level - band;
        sample_x = CMP_W'($signed(sample));
        close_hit = sample_x > $signed({1'b0, upper});
        far_hit   = sample_x < $signed({2'b00, lower});
    end

endmodule

// File: rtl/prox_run_fsm.sv
module prox_run_fsm
    import prox_det_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_valid,
    input  logic             close_hit,
    input  logic             far_hit,
    input  logic [DEB_W-1:0] close_deb,
    input  logic [DEB_W-1:0] far_deb,
    output logic             is_close,
    output logic             close_evt,
    output logic             far_evt
);
    localparam int MAX_RUN = 1 << ((1 << DEB_W) - 1);
    localparam int CNT_W   = $clog2(MAX_RUN + 1);

    prox_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   cnt_inc;
    logic [CNT_W:0]   need_close, need_far;

    function automatic logic [CNT_W:0] run_need(input logic [DEB_W-1:0] code);
        if (code == '0)
            run_need = (CNT_W+1)'(1);
        else
            run_need = (CNT_W+1)'(1) << code;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        need_close = run_need(close_deb);
        need_far   = run_need(far_deb);
        cnt_inc    = {1'b0, cnt_q} + (CNT_W+1)'(1);
        state_d    = state_q;
        cnt_d      = cnt_q;
        if (sample_valid) begin
            unique case (state_q)
                ST_FAR, ST_FAR_ARM: begin
                    if (!close_hit) begin
                        state_d = ST_FAR;
                        cnt_d   = '0;
                    end else if (cnt_inc >= need_close) begin
                        state_d = ST_CLOSE;
                        cnt_d   = '0;
                    end else begin
                        state_d = ST_FAR_ARM;
                        cnt_d   = cnt_inc[CNT_W-1:0];
                    end
                end
                ST_CLOSE, ST_CLOSE_ARM: begin
                    if (!far_hit) begin
                        state_d = ST_CLOSE;
                        cnt_d   = '0;
                    end else if (cnt_inc >= need_far) begin
                        state_d = ST_FAR;
                        cnt_d   = '0;
                    end else begin
                        state_d = ST_CLOSE_ARM;
                        cnt_d   = cnt_inc[CNT_W-1:0];
                    end
                end
                default: begin
                    state_d = ST_FAR;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        is_close  = (state_q == ST_CLOSE) || (state_q == ST_CLOSE_ARM);
        close_evt = sample_valid && !is_close && (state_d == ST_CLOSE);
        far_evt   = sample_valid && is_close && (state_d == ST_FAR);
    end

    p_hold_no_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> ($stable(state_q) && $stable(cnt_q)));

    p_run_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(MAX_RUN));

    p_close_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
        close_evt |-> close_hit);

    p_far_qualified_r4: assert property (@(posedge clk) disable iff (!rst_n)
        far_evt |-> far_hit);

    p_run_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !is_close && !close_hit) |=> (cnt_q == '0));

endmodule

// File: rtl/prox_reg_file.sv
module prox_reg_file
    import prox_det_pkg::*;
#(
    parameter int THR_CODE_W = 8,
    parameter int THR_RESET  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    output logic [REG_DATA_W-1:0] reg_rdata,
    input  logic                  sample_valid,
    input  logic                  close_evt,
    input  logic                  far_evt,
    input  logic                  is_close,
    output logic [THR_CODE_W-1:0] thr_code,
    output tune_t                 tune,
    output logic                  irq
);
    localparam int TUNE_W = $bits(tune_t);

    logic [REG_DATA_W-1:0] src_q, mask_q, src_set, rd_mux;
    logic [THR_CODE_W-1:0] thr_q;
    tune_t                 tune_q;
    logic                  rd_src;

    always_comb begin
        src_set                = '0;
        src_set[SRC_CONV_BIT]  = sample_valid;
        src_set[SRC_FAR_BIT]   = far_evt;
        src_set[SRC_CLOSE_BIT] = close_evt;
        rd_src = reg_rd && (reg_addr == RA_SRC);
    end

    always_comb begin
        case (reg_addr)
            RA_SRC:    rd_mux = src_q;
            RA_STATUS: rd_mux = REG_DATA_W'(is_close);
            RA_MASK:   rd_mux = mask_q;
            RA_THRESH: rd_mux = REG_DATA_W'(thr_q);
            RA_TUNE:   rd_mux = REG_DATA_W'(tune_q);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q     <= '0;
            mask_q    <= '0;
            thr_q     <= THR_CODE_W'(THR_RESET);
            tune_q    <= '0;
            reg_rdata <= '0;
        end else begin
            if (rd_src)
                src_q <= src_set;
            else
                src_q <= src_q | src_set;
            if (reg_rd)
                reg_rdata <= rd_mux;
            if (reg_wr) begin
                case (reg_addr)
                    RA_MASK:   mask_q <= reg_wdata & SRC_USED;
                    RA_THRESH: thr_q  <= reg_wdata[THR_CODE_W-1:0];
                    RA_TUNE:   tune_q <= tune_t'(reg_wdata[TUNE_W-1:0]);
                    default:   ;
                endcase
            end
        end
    end

    assign thr_code = thr_q;
    assign tune     = tune_q;
    assign irq      = |(src_q & mask_q);

    p_conv_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> src_q[SRC_CONV_BIT]);

    p_close_logged_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_close) |-> src_q[SRC_CLOSE_BIT]);

    p_far_logged_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(is_close) |-> src_q[SRC_FAR_BIT]);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_src |=> ((src_q & $past(src_q)) == $past(src_q)));

    p_unused_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q & ~SRC_USED) == '0);

    p_mask_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

endmodule

// File: rtl/prox_event_detect.sv
module prox_event_detect
    import prox_det_pkg::*;
#(
    parameter int SAMPLE_W   = 12,
    parameter int THR_CODE_W = 8,
    parameter int THR_RESET  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_valid,
    input  logic [SAMPLE_W-1:0]   sample_data,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    output logic [REG_DATA_W-1:0] reg_rdata,
    output logic                  prox_close,
    output logic                  irq
);
    localparam int THR_W = 2 * THR_CODE_W;

    logic [THR_CODE_W-1:0] thr_code;
    tune_t                 tune;
    logic [THR_W-1:0]      level, band;
    logic                  close_hit, far_hit;
    logic                  is_close, close_evt, far_evt;

    prox_level_cmp #(
        .SAMPLE_W   (SAMPLE_W),
        .THR_CODE_W (THR_CODE_W)
    ) u_cmp (
        .thr_code  (thr_code),
        .hyst_code (tune.hyst),
        .sample    (sample_data),
        .level     (level),
        .band      (band),
        .close_hit (close_hit),
        .far_hit   (far_hit)
    );

    prox_run_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .close_hit    (close_hit),
        .far_hit      (far_hit),
        .close_deb    (tune.close_deb),
        .far_deb      (tune.far_deb),
        .is_close     (is_close),
        .close_evt    (close_evt),
        .far_evt      (far_evt)
    );

    prox_reg_file #(
        .THR_CODE_W (THR_CODE_W),
        .THR_RESET  (THR_RESET)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .sample_valid (sample_valid),
        .close_evt    (close_evt),
        .far_evt      (far_evt),
        .is_close     (is_close),
        .thr_code     (thr_code),
        .tune         (tune),
        .irq          (irq)
    );

    assign prox_close = is_close;

    p_band_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        band <= (level >> 2));

    p_hits_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(close_hit && far_hit));

endmodule

// File: tb/prox_event_detect_tb.sv
module prox_event_detect_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sample_valid;
    logic [11:0] sample_data;
    logic        reg_wr, reg_rd;
    logic [2:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        prox_close;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    prox_event_detect u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .sample_data  (sample_data),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .prox_close   (prox_close),
        .irq          (irq)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input int s);
        @(negedge clk);
        sample_valid = 1'b1;
        sample_data  = s[11:0];
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a[2:0];
        reg_wdata = d[7:0];
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_rd   = 1'b1;
        reg_addr = a[2:0];
        @(negedge clk);
        reg_rd = 1'b0;
        d = int'(reg_rdata);
    endtask

    function automatic int exp_level(input int c);
        return (c <= 1) ? c : (c * c) / 2;
    endfunction

    function automatic int exp_band(input int t, input int h);
        return (h == 0) ? 0 : (t >> (5 - h));
    endfunction

    function automatic int run_len(input int code);
        return (code == 0) ? 1 : (1 << code);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        int v;
        rst_n = 1'b0;
        sample_valid = 1'b0;
        sample_data = '0;
        reg_wr = 1'b0;
        reg_rd = 1'b0;
        reg_addr = '0;
        reg_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        chk(int'(prox_close), 0, "R11 reset far");
        chk(int'(irq), 0, "R9 reset irq");
        rd(0, v); chk(v, 0, "R7 reset source");
        rd(1, v); chk(v, 0, "R11 reset status");
        rd(2, v); chk(v, 0, "R10 reset mask");
        rd(3, v); chk(v, 8, "R1 reset threshold code");
        rd(4, v); chk(v, 0, "R10 reset tune");

        // reset level 32: boundary around it
        send(32); chk(int'(prox_close), 0, "R1 level 32 not exceeded");
        send(33); chk(int'(prox_close), 1, "R1 level 32 exceeded");
        send(32); chk(int'(prox_close), 1, "R2 at level holds close");
        send(31); chk(int'(prox_close), 0, "R2 below level far");

        // level and band sweep, no debounce
        for (int c = 0; c < 64; c++) begin
            for (int h = 0; h < 4; h++) begin
                int t, b;
                t = exp_level(c);
                b = exp_band(t, h);
                if (t + b + 1 <= 2047) begin
                    wr(3, c);
                    wr(4, h << 4);
                    send(-2048);
                    chk(int'(prox_close), 0, "R2 sweep start far");
                    send(t + b);
                    chk(int'(prox_close), 0, "R1 sweep upper edge no close");
                    send(t + b + 1);
                    chk(int'(prox_close), 1, "R1 sweep above upper close");
                    send(t - b);
                    chk(int'(prox_close), 1, "R2 sweep lower edge holds");
                    send(t - b - 1);
                    chk(int'(prox_close), 0, "R2 sweep below lower far");
                end
            end
        end

        // debounce sweep, level 32, no band
        wr(3, 8);
        for (int cd = 0; cd < 4; cd++) begin
            for (int fd = 0; fd < 4; fd++) begin
                int nc, nf;
                nc = run_len(cd);
                nf = run_len(fd);
                wr(4, (fd << 2) | cd);
                for (int i = 0; i < 8; i++) send(-100);
                chk(int'(prox_close), 0, "R4 debounce start far");
                for (int i = 0; i < nc - 1; i++) send(100);
                chk(int'(prox_close), 0, "R3 one short of close run");
                send(32);
                for (int i = 0; i < nc - 1; i++) send(100);
                chk(int'(prox_close), 0, "R5 close run restarted");
                repeat (7) @(negedge clk);
                chk(int'(prox_close), 0, "R6 idle keeps far");
                send(100);
                chk(int'(prox_close), 1, "R3 close run complete");
                for (int i = 0; i < nf - 1; i++) send(-100);
                chk(int'(prox_close), 1, "R4 one short of far run");
                send(32);
                for (int i = 0; i < nf - 1; i++) send(-100);
                chk(int'(prox_close), 1, "R5 far run restarted");
                send(-100);
                chk(int'(prox_close), 0, "R4 far run complete");
            end
        end

        // strobe-free cycles with a qualifying value on the bus
        wr(4, 0);
        @(negedge clk);
        sample_data = 12'd100;
        repeat (10) @(negedge clk);
        chk(int'(prox_close), 0, "R6 no strobe no change");

        // event bits
        rd(0, v);
        rd(0, v); chk(v, 0, "R8 cleared after read");
        send(32);
        rd(0, v); chk(v, 1, "R7 conversion done only");
        rd(0, v); chk(v, 0, "R8 second read empty");
        send(100);
        rd(1, v); chk(v, 1, "R11 status close");
        rd(0, v); chk(v, 9, "R7 close event plus done");
        send(-100);
        rd(1, v); chk(v, 0, "R11 status far");
        rd(0, v); chk(v, 5, "R7 far event plus done");

        // read racing a strobe
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 3'd0;
        sample_valid = 1'b1; sample_data = 12'd32;
        @(negedge clk);
        reg_rd = 1'b0; sample_valid = 1'b0;
        chk(int'(reg_rdata), 0, "R8 race read returns old");
        rd(0, v); chk(v, 1, "R8 race event kept");

        // mask sweep
        for (int m = 0; m < 16; m++) begin
            wr(2, m);
            rd(2, v); chk(v, m & 13, "R9 mask readback");
            chk(int'(irq), 0, "R9 nothing pending");
            send(100);
            send(-100);
            chk(int'(irq), ((m & 13) != 0) ? 1 : 0, "R9 masked irq");
            rd(0, v); chk(v, 13, "R7 all events pending");
            chk(int'(irq), 0, "R9 irq drops after clear");
        end
        wr(2, 0);

        // read-only and unmapped addresses
        wr(0, 255);
        rd(0, v); chk(v, 0, "R10 source write ignored");
        wr(1, 255);
        chk(int'(prox_close), 0, "R10 status write ignored");
        wr(6, 255);
        rd(6, v); chk(v, 0, "R10 unmapped reads zero");
        rd(3, v); chk(v, 8, "R10 threshold untouched");
        rd(4, v); chk(v, 0, "R10 tune untouched");
        rd(2, v); chk(v, 0, "R10 mask untouched");
        wr(4, 63);
        rd(4, v); chk(v, 63, "R10 tune readback");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule